// File: doc/BRIEF.md
# Switch Adder with Hexadecimal and Decimal Digit Display

This block reads two 8-bit unsigned operands from an 18-bit switch vector and adds them. It drives eight seven-segment digit outputs. The upper four digits show the two operands in hexadecimal, two digits per operand. The lower four digits show the 9-bit sum in decimal.

The block has no clock and no stored state. Every output follows the switches combinationally, so the digits change as soon as a switch is toggled.

The decimal digits come from a shift-and-add-3 binary-to-BCD conversion of the sum. Each hexadecimal or decimal value then passes through a shared glyph decoder. Segments are active low: a 0 lights the segment. Within each 7-bit output, bit 6 is segment g, bit 5 is f, bit 4 is e, bit 3 is d, bit 2 is c, bit 1 is b and bit 0 is a.

Top module: `switch_sum_display`

## Requirements
- R1: Operand A is taken from sw_i[16:9]. Its high nibble appears on digit7_o and its low nibble on digit6_o, in hexadecimal.
- R2: Operand B is taken from sw_i[7:0]. Its high nibble appears on digit5_o and its low nibble on digit4_o, in hexadecimal.
- R3: sw_i[17] and sw_i[8] have no effect on any output.
- R4: The active-low glyph codes (bit 6 = g down to bit 0 = a) are as follows.
  - Decimal digits: 0=0x40, 1=0x79, 2=0x24, 3=0x30, 4=0x19, 5=0x12, 6=0x02, 7=0x78, 8=0x00, 9=0x10.
  - Hex letters: A=0x08, b=0x03, C=0x46, d=0x21, E=0x06, F=0x0E.
- R5: The sum is 9 bits wide and keeps the carry out. The largest sum, 255+255=510, is shown as 0,5,1,0 on digits 3 to 0.
- R6: digit2_o shows the hundreds digit of the sum, digit1_o the tens digit and digit0_o the ones digit. Leading zeros are shown, not blanked.
- R7: digit3_o always shows the glyph for 0.
- R8: All outputs are combinational functions of sw_i and are valid within the same cycle that the switches change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sw_i | input | 18 | Switch vector carrying both operands |
| digit7_o | output | 7 | Operand A, high hex nibble |
| digit6_o | output | 7 | Operand A, low hex nibble |
| digit5_o | output | 7 | Operand B, high hex nibble |
| digit4_o | output | 7 | Operand B, low hex nibble |
| digit3_o | output | 7 | Sum, thousands digit (always 0) |
| digit2_o | output | 7 | Sum, hundreds digit |
| digit1_o | output | 7 | Sum, tens digit |
| digit0_o | output | 7 | Sum, ones digit |

## Verification
The hexadecimal operand display and the decimal sum display both respond to the same switch change in the same cycle. A slicing fault in one operand therefore shows up in both digit groups together.

The bench provokes this by walking every operand pair. For each pair it sets the two unused switch bits from a pattern tied to the operands. Half a cycle later it judges all eight digits against glyphs it computes itself, using division and modulus for the decimal digits. Separate vectors toggle only the unused bits while holding the operands fixed.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int OPND_W  = 8;
    localparam int SUM_W   = OPND_W + 1;
    localparam int NIB_W   = 4;
    localparam int SEG_W   = 7;
    localparam int SW_W    = 2 * OPND_W + 2;
    localparam int DEC_DIG = 4;
    localparam int NUM_DIG = 2 * (OPND_W / NIB_W) + DEC_DIG;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/glyph_rom.sv
module glyph_rom
    import disp_pkg::*;
(
    input  nib_t nib_i,
    output seg_t seg_o
);
    // active low, bit6 = g ... bit0 = a
    always_comb begin
        unique case (nib_i)
            4'h0: seg_o = 7'h40;
            4'h1: seg_o = 7'h79;
            4'h2: seg_o = 7'h24;
            4'h3: seg_o = 7'h30;
            4'h4: seg_o = 7'h19;
            4'h5: seg_o = 7'h12;
            4'h6: seg_o = 7'h02;
            4'h7: seg_o = 7'h78;
            4'h8: seg_o = 7'h00;
            4'h9: seg_o = 7'h10;
            4'hA: seg_o = 7'h08;
            4'hB: seg_o = 7'h03;
            4'hC: seg_o = 7'h46;
            4'hD: seg_o = 7'h21;
            4'hE: seg_o = 7'h06;
            default: seg_o = 7'h0E;
        endcase
    end
endmodule

// File: rtl/bcd_shift_add3.sv
module bcd_shift_add3 #(
    parameter int IN_W   = 9,
    parameter int DIGITS = 4
) (
    input  logic [IN_W-1:0]     bin_i,
    output logic [DIGITS*4-1:0] bcd_o
);
    localparam int BCD_W = DIGITS * 4;

    logic [BCD_W-1:0] acc;

    // Shift-and-add-3: before each shift, any digit >= 5 is corrected by +3.
    always_comb begin
        acc = '0;
        for (int bit_idx = IN_W - 1; bit_idx >= 0; bit_idx--) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (acc[d*4 +: 4] >= 4'd5) begin
                    acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
                end
            end
            acc = {acc[BCD_W-2:0], bin_i[bit_idx]};
        end
        bcd_o = acc;
    end
endmodule

// File: rtl/switch_sum_display.sv
module switch_sum_display
    import disp_pkg::*;
(
    input  logic [17:0] sw_i,
    output logic [6:0]  digit7_o,
    output logic [6:0]  digit6_o,
    output logic [6:0]  digit5_o,
    output logic [6:0]  digit4_o,
    output logic [6:0]  digit3_o,
    output logic [6:0]  digit2_o,
    output logic [6:0]  digit1_o,
    output logic [6:0]  digit0_o
);
    localparam int A_LSB = OPND_W + 1;

    logic [OPND_W-1:0]        opnd_a;
    logic [OPND_W-1:0]        opnd_b;
    logic [SUM_W-1:0]         sum;
    logic [DEC_DIG*NIB_W-1:0] sum_bcd;
    nib_t [NUM_DIG-1:0]       nib;
    seg_t [NUM_DIG-1:0]       seg;

    // sw_i[17] and sw_i[8] are deliberately unused
    assign opnd_a = sw_i[A_LSB +: OPND_W];
    assign opnd_b = sw_i[0 +: OPND_W];
    assign sum    = {1'b0, opnd_a} + {1'b0, opnd_b};

    bcd_shift_add3 #(
        .IN_W  (SUM_W),
        .DIGITS(DEC_DIG)
    ) u_bcd (
        .bin_i(sum),
        .bcd_o(sum_bcd)
    );

    assign nib[7] = opnd_a[7:4];
    assign nib[6] = opnd_a[3:0];
    assign nib[5] = opnd_b[7:4];
    assign nib[4] = opnd_b[3:0];

    genvar g;
    generate
        for (g = 0; g < DEC_DIG; g++) begin : g_dec
            assign nib[g] = sum_bcd[g*NIB_W +: NIB_W];
        end
        for (g = 0; g < NUM_DIG; g++) begin : g_glyph
            glyph_rom u_glyph (
                .nib_i(nib[g]),
                .seg_o(seg[g])
            );
        end
    endgenerate

    assign digit7_o = seg[7];
    assign digit6_o = seg[6];
    assign digit5_o = seg[5];
    assign digit4_o = seg[4];
    assign digit3_o = seg[3];
    assign digit2_o = seg[2];
    assign digit1_o = seg[1];
    assign digit0_o = seg[0];
endmodule

// File: rtl/switch_sum_display_chk.sv
module switch_sum_display_chk (
    input logic [17:0] sw_i,
    input logic [6:0]  digit7_o,
    input logic [6:0]  digit6_o,
    input logic [6:0]  digit5_o,
    input logic [6:0]  digit4_o,
    input logic [6:0]  digit3_o,
    input logic [6:0]  digit2_o,
    input logic [6:0]  digit1_o,
    input logic [6:0]  digit0_o
);
    // Reverse map: glyph back to value; 31 marks an illegal pattern.
    function automatic logic [4:0] glyph_val(input logic [6:0] s);
        case (s)
            7'h40: glyph_val = 5'd0;
            7'h79: glyph_val = 5'd1;
            7'h24: glyph_val = 5'd2;
            7'h30: glyph_val = 5'd3;
            7'h19: glyph_val = 5'd4;
            7'h12: glyph_val = 5'd5;
            7'h02: glyph_val = 5'd6;
            7'h78: glyph_val = 5'd7;
            7'h00: glyph_val = 5'd8;
            7'h10: glyph_val = 5'd9;
            7'h08: glyph_val = 5'd10;
            7'h03: glyph_val = 5'd11;
            7'h46: glyph_val = 5'd12;
            7'h21: glyph_val = 5'd13;
            7'h06: glyph_val = 5'd14;
            7'h0E: glyph_val = 5'd15;
            default: glyph_val = 5'd31;
        endcase
    endfunction

    logic [9:0] shown_a, shown_b, shown_sum, true_sum;

    always_comb begin
        shown_a   = 10'(glyph_val(digit7_o)) * 10'd16 + 10'(glyph_val(digit6_o));
        shown_b   = 10'(glyph_val(digit5_o)) * 10'd16 + 10'(glyph_val(digit4_o));
        shown_sum = 10'(glyph_val(digit2_o)) * 10'd100
                  + 10'(glyph_val(digit1_o)) * 10'd10
                  + 10'(glyph_val(digit0_o));
        true_sum  = 10'(sw_i[16:9]) + 10'(sw_i[7:0]);
    end

    always_comb begin
        assert_opnd_a_R1: assert (shown_a == 10'(sw_i[16:9]));
        assert_opnd_b_R2: assert (shown_b == 10'(sw_i[7:0]));
        assert_msd_zero_R7: assert (digit3_o == 7'h40);
        assert_dec_range_R6: assert (glyph_val(digit2_o) <= 5'd9 &&
                                     glyph_val(digit1_o) <= 5'd9 &&
                                     glyph_val(digit0_o) <= 5'd9);
        assert_sum_R5: assert (shown_sum == true_sum);
    end
endmodule

bind switch_sum_display switch_sum_display_chk u_chk (
    .sw_i    (sw_i),
    .digit7_o(digit7_o),
    .digit6_o(digit6_o),
    .digit5_o(digit5_o),
    .digit4_o(digit4_o),
    .digit3_o(digit3_o),
    .digit2_o(digit2_o),
    .digit1_o(digit1_o),
    .digit0_o(digit0_o)
);

// File: tb/sim_switch_sum_display.sv
`timescale 1ns/1ps
module sim_switch_sum_display;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] sw = '0;
    logic [6:0]  d7, d6, d5, d4, d3, d2, d1, d0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] exp [8];
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    switch_sum_display u0 (
        .sw_i    (sw),
        .digit7_o(d7),
        .digit6_o(d6),
        .digit5_o(d5),
        .digit4_o(d4),
        .digit3_o(d3),
        .digit2_o(d2),
        .digit1_o(d1),
        .digit0_o(d0)
    );

    // R4 glyph codes, taken from the requirement
    function automatic logic [6:0] glyph(input int v);
        case (v)
            0: return 7'h40;
            1: return 7'h79;
            2: return 7'h24;
            3: return 7'h30;
            4: return 7'h19;
            5: return 7'h12;
            6: return 7'h02;
            7: return 7'h78;
            8: return 7'h00;
            9: return 7'h10;
            10: return 7'h08;
            11: return 7'h03;
            12: return 7'h46;
            13: return 7'h21;
            14: return 7'h06;
            default: return 7'h0E;
        endcase
    endfunction

    task automatic drive(input int a, input int b, input bit x17, input bit x8,
                         input string tag);
        item_t it;
        int s;
        s = a + b;
        @(posedge clk);
        sw = {x17, 8'(a), x8, 8'(b)};
        it.exp[7] = glyph(a / 16);
        it.exp[6] = glyph(a % 16);
        it.exp[5] = glyph(b / 16);
        it.exp[4] = glyph(b % 16);
        it.exp[3] = glyph(s / 1000);
        it.exp[2] = glyph((s / 100) % 10);
        it.exp[1] = glyph((s / 10) % 10);
        it.exp[0] = glyph(s % 10);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic cmp(input logic [6:0] act, input logic [6:0] exp,
                       input string req, input int dig, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s digit%0d (%s) sw=%h actual=%h expected=%h",
                     req, dig, tag, sw, act, exp);
        end
    endtask

    // monitor: sample mid-cycle, after the driver's posedge update
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            cmp(d7, it.exp[7], "R1", 7, it.tag);
            cmp(d6, it.exp[6], "R1", 6, it.tag);
            cmp(d5, it.exp[5], "R2", 5, it.tag);
            cmp(d4, it.exp[4], "R2", 4, it.tag);
            cmp(d3, it.exp[3], "R7", 3, it.tag);
            cmp(d2, it.exp[2], "R6", 2, it.tag);
            cmp(d1, it.exp[1], "R6", 1, it.tag);
            cmp(d0, it.exp[0], "R5", 0, it.tag);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // initial state: all zero switches -> 00 00 0000 (R8)
        drive(0, 0, 1'b0, 1'b0, "R8 zero");
        // R5 maximum sum 510 keeps carry
        drive(255, 255, 1'b0, 1'b0, "R5 max");
        // R4 letter glyphs
        drive(8'hAB, 8'hCD, 1'b0, 1'b0, "R4 letters");
        drive(8'hEF, 8'h19, 1'b0, 1'b0, "R4 letters");
        // R3 toggle only the unused bits with operands fixed
        for (int k = 0; k < 4; k++) begin
            drive(8'h5A, 8'hC3, k[1], k[0], "R3 unused");
        end
        // exhaustive sweep; unused bits follow an operand-tied pattern (R3)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive(a, b, a[0] ^ b[3], b[0] ^ a[5], "sweep");
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule